// File: doc/BRIEF.md
# Processor speculation level controller

This block holds the global speculation level of an out-of-order core and decides whether a waiting load may run ahead of stores whose addresses are still unknown. A speculation level is a 2-bit color: 0 means no speculation, and 3 is the most aggressive level. Every load carries a predicted color. The load may issue past unresolved stores only when its color is no higher than the core's effective color.

The level rises when the memory ports have been lightly used. Lightly used means that, over a fixed epoch of cycles, the total count of port uses falls below a threshold. Two policies are selectable.
- In the basic policy, the level climbs one step per light epoch. The effective color is clamped to the lowest color among the stores now in the window. This color comes from one counter per color, so the window is never scanned.
- In the aggressive policy, a light epoch jumps the level to the maximum. The level steps down once for each store that enters the window flagged as having collided before.

Top module: `spec_level_ctrl`

## Requirements
- R1: After reset, proc_color and eff_color are 0. A load of color 0 is eligible and a load of color 1 is not.
- R2: Basic policy (aggressive_mode=0). An epoch is EPOCH cycles (default 8), counted from reset release. If the epoch's total count of set port_used bits is below LOW_USES (default 4), proc_color rises by one at the epoch's last edge and saturates at 3. An epoch with more uses leaves proc_color unchanged.
- R3: Aggressive policy (aggressive_mode=1). A light epoch sets proc_color to 3.
- R4: Aggressive policy. A store entering with st_enter_collide=1 lowers proc_color by one at that edge, saturating at 0. In the basic policy the collide flag has no effect on proc_color.
- R5: Basic policy. eff_color is the smaller of proc_color and the lowest color that has at least one store in the window. With no store in the window, eff_color equals proc_color.
- R6: Aggressive policy. eff_color equals proc_color whatever stores are in the window.
- R7: A store entry and a store leave in the same cycle are both applied. Entry and leave of the same color leave that color's count unchanged.
- R8: ld_issue_ok is 1 exactly when ld_color <= eff_color, as unsigned 2-bit values. Color 0 is therefore always eligible.
- R9: Aggressive policy. When a light epoch ends in the same cycle as a colliding store enters, the level is first set to 3 and then decremented, which gives 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aggressive_mode | input | 1 | 1 selects the aggressive policy, 0 selects the basic policy |
| port_used | input | NPORTS | One bit per memory port used this cycle |
| st_enter_vld | input | 1 | A store enters the window |
| st_enter_color | input | CLR_W | Color of the entering store |
| st_enter_collide | input | 1 | The entering store is marked as having collided |
| st_leave_vld | input | 1 | A store retires or is flushed from the window |
| st_leave_color | input | CLR_W | Color of the leaving store |
| ld_color | input | CLR_W | Predicted color of the candidate load |
| proc_color | output | CLR_W | Registered global speculation level |
| eff_color | output | CLR_W | Level that loads are compared against |
| ld_issue_ok | output | 1 | Candidate load may issue speculatively |

## Verification
Two situations are hard to reach from the ports: a light epoch that ends in exactly the same cycle as a colliding store arrives, and a light epoch that starts on an epoch boundary. The bench keeps its own count of cycles since reset, which is derived from the epoch rule and not read from the design. With that count it starts idle periods on a boundary and places the colliding store on the epoch's final cycle. Store counts by color are kept in the bench, so the expected clamp follows from the entries and leaves alone.

// File: rtl/spec_level_ctrl.sv
module spec_level_ctrl #(
  parameter int CLR_W     = 2,
  parameter int WIN_DEPTH = 64,
  parameter int NPORTS    = 2,
  parameter int EPOCH     = 8,
  parameter int LOW_USES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aggressive_mode,
  input  logic [NPORTS-1:0] port_used,
  input  logic              st_enter_vld,
  input  logic [CLR_W-1:0]  st_enter_color,
  input  logic              st_enter_collide,
  input  logic              st_leave_vld,
  input  logic [CLR_W-1:0]  st_leave_color,
  input  logic [CLR_W-1:0]  ld_color,
  output logic [CLR_W-1:0]  proc_color,
  output logic [CLR_W-1:0]  eff_color,
  output logic              ld_issue_ok
);
  localparam int NCOL = 1 << CLR_W;
  localparam logic [CLR_W-1:0] MAXC = CLR_W'(NCOL - 1);
  localparam int CW = $clog2(WIN_DEPTH + 1);
  localparam int EW = $clog2(EPOCH);
  localparam int AW = $clog2(EPOCH * NPORTS + 1);

  logic [CW-1:0]    cnt_q [NCOL];
  logic [EW-1:0]    ep_q;
  logic [AW-1:0]    acc_q, use_sum;
  logic [CLR_W-1:0] proc_q, proc_d, min_st;
  logic             has_st, epoch_last, low_util, coll_in;

  assign use_sum    = acc_q + AW'($countones(port_used));
  assign epoch_last = (ep_q == EW'(EPOCH - 1));
  assign low_util   = epoch_last && (use_sum < AW'(LOW_USES));
  assign coll_in    = aggressive_mode && st_enter_vld && st_enter_collide;

  always_comb begin
    proc_d = proc_q;
    if (low_util) proc_d = aggressive_mode ? MAXC : ((proc_q == MAXC) ? proc_q : proc_q + 1'b1);
    if (coll_in && proc_d != '0) proc_d = proc_d - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ep_q   <= '0;
      acc_q  <= '0;
      proc_q <= '0;
    end else begin
      ep_q   <= epoch_last ? '0 : ep_q + 1'b1;
      acc_q  <= epoch_last ? '0 : use_sum;
      proc_q <= proc_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCOL; c++) begin
      if (!rst_n) cnt_q[c] <= '0;
      else cnt_q[c] <= cnt_q[c]
                      + CW'(st_enter_vld && st_enter_color == CLR_W'(c))
                      - CW'(st_leave_vld && st_leave_color == CLR_W'(c));
    end
  end

  always_comb begin
    has_st = 1'b0;
    min_st = MAXC;
    for (int c = NCOL - 1; c >= 0; c--) begin
      if (cnt_q[c] != '0) begin
        has_st = 1'b1;
        min_st = CLR_W'(c);
      end
    end
  end

  assign proc_color  = proc_q;
  assign eff_color   = (!aggressive_mode && has_st && min_st < proc_q) ? min_st : proc_q;
  assign ld_issue_ok = (ld_color <= eff_color);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!aggressive_mode && !epoch_last) |=> proc_color == $past(proc_color));
  p_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!aggressive_mode && low_util && proc_color != MAXC) |=> proc_color == $past(proc_color) + 1'b1);
  p_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aggressive_mode && low_util && !st_enter_vld) |=> proc_color == MAXC);
  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (coll_in && !epoch_last && proc_color != '0) |=> proc_color == $past(proc_color) - 1'b1);
  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eff_color <= proc_color);
  p_zero_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_color == '0) |-> ld_issue_ok);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_enter_vld |-> cnt_q[st_enter_color] != CW'(WIN_DEPTH));
endmodule

// File: tb/sim_spec_level_ctrl.sv
`timescale 1ns/1ps
module sim_spec_level_ctrl;
  logic clk = 0, rst_n = 0, aggr = 0;
  logic [1:0] pu = 2'b11;
  logic ev = 0, ecol = 0, lv = 0;
  logic [1:0] ec = 0, lc = 0, ldc = 0;
  logic [1:0] pc, effc;
  logic ok;
  int checks = 0, fails = 0, ph = 0;
  int cnt [4] = '{0, 0, 0, 0};
  int model_proc = 0;

  always #2 clk = ~clk;

  spec_level_ctrl u0 (.clk(clk), .rst_n(rst_n), .aggressive_mode(aggr), .port_used(pu),
    .st_enter_vld(ev), .st_enter_color(ec), .st_enter_collide(ecol),
    .st_leave_vld(lv), .st_leave_color(lc), .ld_color(ldc),
    .proc_color(pc), .eff_color(effc), .ld_issue_ok(ok));

  always @(posedge clk) ph <= rst_n ? (ph + 1) % 8 : 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_eff();
    int m = model_proc;
    if (!aggr) for (int c = 3; c >= 0; c--) if (cnt[c] != 0 && c < m) m = c;
    return m;
  endfunction

  task automatic st_op(bit e, int ecl, bit col, bit l, int lcl);
    @(negedge clk);
    ev = e; ec = 2'(ecl); ecol = col; lv = l; lc = 2'(lcl);
    @(negedge clk);
    ev = 0; ecol = 0; lv = 0;
    if (e) cnt[ecl]++;
    if (l) cnt[lcl]--;
  endtask

  task automatic idle_epoch();
    @(negedge clk);
    while (ph != 0) @(negedge clk);
    pu = 2'b00;
    repeat (8) @(negedge clk);
    pu = 2'b11;
  endtask

  task automatic t_reset();
    chk("R1 proc", int'(pc), 0);
    chk("R1 eff", int'(effc), 0);
    ldc = 0; #0.1 chk("R1 ld0 ok", int'(ok), 1);
    ldc = 1; #0.1 chk("R1 ld1 blocked", int'(ok), 0);
  endtask

  task automatic t_basic_raise();
    aggr = 0;
    idle_epoch(); model_proc = 1;
    chk("R2 raise to 1", int'(pc), 1);
    repeat (16) @(negedge clk);
    chk("R2 busy epochs hold", int'(pc), 1);
    repeat (3) idle_epoch();
    model_proc = 3;
    chk("R2 saturate at 3", int'(pc), 3);
    st_op(1, 3, 1, 0, 0);
    chk("R4 basic ignores collide", int'(pc), 3);
    st_op(0, 0, 0, 1, 3);
  endtask

  task automatic t_min();
    st_op(1, 2, 0, 0, 0);
    chk("R5 clamp to 2", int'(effc), exp_eff());
    st_op(1, 1, 0, 0, 0);
    chk("R5 clamp to 1", int'(effc), 1);
    ldc = 2; #0.1 chk("R8 ld2 blocked", int'(ok), 0);
    ldc = 1; #0.1 chk("R8 ld1 ok", int'(ok), 1);
    st_op(0, 0, 0, 1, 1);
    chk("R5 back to 2", int'(effc), 2);
    st_op(0, 0, 0, 1, 2);
    chk("R5 empty window", int'(effc), 3);
  endtask

  task automatic t_same_cycle();
    st_op(1, 2, 0, 0, 0);
    st_op(1, 1, 0, 1, 2);
    chk("R7 enter1 leave2", int'(effc), 1);
    st_op(1, 1, 0, 1, 1);
    chk("R7 same color net zero", int'(effc), 1);
    st_op(0, 0, 0, 1, 1);
    chk("R7 drained", int'(effc), exp_eff());
  endtask

  task automatic t_aggr();
    aggr = 1;
    st_op(1, 0, 0, 0, 0);
    chk("R6 stores ignored", int'(effc), 3);
    for (int i = 2; i >= 0; i--) begin
      st_op(1, 3, 1, 0, 0);
      chk("R4 decrement", int'(pc), i);
    end
    st_op(1, 3, 1, 0, 0);
    chk("R4 saturate at 0", int'(pc), 0);
    idle_epoch();
    chk("R3 jump to max", int'(pc), 3);
    st_op(1, 3, 1, 0, 0);
    chk("R4 decrement from max", int'(pc), 2);
    @(negedge clk);
    while (ph != 0) @(negedge clk);
    pu = 2'b00;
    repeat (7) @(negedge clk);
    ev = 1; ec = 3; ecol = 1;
    @(negedge clk);
    ev = 0; ecol = 0; pu = 2'b11; cnt[3]++;
    model_proc = 2;
    chk("R9 max then decrement", int'(pc), 2);
    aggr = 0; #0.1
    chk("R5 basic clamp by color0 store", int'(effc), exp_eff());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic_raise();
    t_min();
    t_same_cycle();
    t_aggr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule